// File: doc/BRIEF.md
# Compare Match Timer Channel Group

This block holds a group of timer channels behind one small register interface. Each channel has an up-counter, a compare register and a control/status register. The counter advances on a tick taken from a prescaler that runs all the time. When the count equals the compare value at a tick, the counter returns to zero and a match flag is set. While interrupts are enabled for that channel, the flag drives an interrupt line. One start register, shared by all channels, holds one run bit per channel.

Software writes a register with a single-cycle write strobe and reads it through a combinational read port. Neither path has back-pressure. A write is accepted in the cycle it is presented, and read data follows the address in the same cycle. The counter behaves as if it were clocked in a slow domain: a value written to it is held aside and loaded only at the second prescaler tick after the write. Until then, reads return the old count and counting goes on unchanged. The counter width, either 16 or 32 bits, is a parameter. It sets the byte spacing of the channel registers and the positions of the status bits.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every control/status register and every counter reads 0, every compare register reads all ones, the start register reads 0 and no interrupt line is high.
- R2: The start register sits at byte address 0. Channel n starts at byte address 16 + 16*n. Within a channel, register index 0 is control/status, 1 is counter and 2 is compare, and the byte offset is the index shifted left by 1 for a 16-bit counter or by 2 for a 32-bit counter. Start-register bits above the channel count, and addresses that map to no register, read 0.
- R3: Channel n counts only while start-register bit n is 1. Writing the start register changes no other channel's count.
- R4: Control bits [1:0] select the tick rate. A tick occurs every 2^(3 + 2*sel) clock cycles: sel 0 gives 8 cycles and sel 3 gives 512 cycles. The 16-bit setting 0x43 therefore ticks every 512 cycles.
- R5: When the counter equals the compare value at a tick, the counter becomes 0 and the match flag is set. Between two matches there are compare + 1 ticks.
- R6: The match flag is control bit 7 for a 16-bit counter and bit 15 for a 32-bit counter. The 32-bit variant also has an overflow flag at bit 14. Writing 0 to a flag clears it, writing 1 leaves it as it is, and every other control bit takes the written value.
- R7: An interrupt line is high exactly while its match flag and its enable bit are both set. The enable bit is bit 6 for a 16-bit counter and bit 5 for a 32-bit counter. Writing 0 to the control register drops the line.
- R8: A counter write is not visible on readback until the second tick of that channel after the write. The value then loads whether or not the channel is running.
- R9: The compare register may be rewritten while the channel runs, and the new value is used from the next tick. If the new value is below the current count, the counter runs to all ones and wraps to 0 without a match flag, then matches on the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address for the write and for the read port |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
The assertions assume that each write strobe lasts one cycle and that its address and data are valid during that cycle. They also assume that reset is held across at least one clock edge. The flag checks take for granted that software clears a flag only by writing 0 to it.

The stimulus drives every input at the falling clock edge with one-cycle strobes. It writes only mapped addresses, except for one read of an unmapped address. Random compare values are kept small so that each period finishes quickly. Counter loads are done with the channel stopped, so the value to expect on readback does not depend on when the counter ticks.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CSR_W = 16;
  localparam int PRE_W = 9;
  localparam int IDX_CSR = 0;
  localparam int IDX_CNT = 1;
  localparam int IDX_CMP = 2;

  // low prescaler bits that must all be ones for a tick of the chosen rate
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] sel);
    return PRE_W'((1 << (3 + 2 * int'(sel))) - 1);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] pre_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic             wr_csr,
  input  logic             wr_cnt,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  output logic [CSR_W-1:0] csr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq
);
  localparam bit WIDE = (CNT_W != 16);
  localparam int FLAG_BIT = WIDE ? 15 : 7;
  localparam int IE_BIT = WIDE ? 5 : 6;
  localparam int OVF_BIT = 14;
  localparam logic [CSR_W-1:0] STAT_MASK = WIDE ? 16'hC000 : 16'h0080;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] mask;
  logic tick, land, step, hit_match, hit_wrap;
  logic [1:0] pend_q;
  logic [CNT_W-1:0] pend_val_q;
  logic [CSR_W-1:0] csr_n, wr16;

  assign mask      = div_mask(csr_q[1:0]);
  assign tick      = ((pre & mask) == mask);
  assign land      = tick && (pend_q == 2'd1);
  assign step      = tick && run && !land;
  assign hit_match = step && (cnt_q == cmp_q);
  assign hit_wrap  = step && (cnt_q == CNT_MAX) && !hit_match;
  assign wr16      = wdata[CSR_W-1:0];
  assign irq       = csr_q[FLAG_BIT] && csr_q[IE_BIT];

  always_comb begin
    csr_n = csr_q;
    if (wr_csr) csr_n = (wr16 & ~STAT_MASK) | (csr_q & wr16 & STAT_MASK);
    if (hit_match) csr_n[FLAG_BIT] = 1'b1;
    if (WIDE && hit_wrap) csr_n[OVF_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q      <= '0;
      cnt_q      <= '0;
      cmp_q      <= '1;
      pend_q     <= '0;
      pend_val_q <= '0;
    end else begin
      csr_q <= csr_n;
      if (wr_cmp) cmp_q <= wdata;
      if (wr_cnt) begin
        pend_q     <= 2'd2;
        pend_val_q <= wdata;
      end else if (tick && pend_q != 2'd0) begin
        pend_q <= pend_q - 2'd1;
      end
      if (land)                       cnt_q <= pend_val_q;
      else if (hit_match || hit_wrap) cnt_q <= '0;
      else if (step)                  cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the count moves only at an edge that carries a tick
  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R3: a stopped channel with no pending load keeps its count
  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && pend_q == 2'd0) |=> $stable(cnt_q));
  // R8: a count write is not visible in the next cycle
  a_r8_write_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !run) |=> $stable(cnt_q));
  // R5: the flag rises only at a running tick, and the count is then zero
  a_r5_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_q[FLAG_BIT]) |-> ($past(tick && run) && cnt_q == '0));
  // R6: writing 1 to a clear flag does not set it
  a_r6_write_cannot_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && !csr_q[FLAG_BIT] && !tick) |=> !csr_q[FLAG_BIT]);
  // R7: writing 0 to the flag drops the interrupt
  a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && !wr16[FLAG_BIT] && !tick) |=> !irq);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int SHIFT     = (CNT_W == 16) ? 1 : 2;
  localparam int CH_BASE   = 16;
  localparam int CH_STRIDE = 16;
  localparam logic [ADDR_W-1:0] START_ADDR = '0;

  function automatic logic [ADDR_W-1:0] reg_addr(input int ch, input int idx);
    return ADDR_W'(CH_BASE + ch * CH_STRIDE + (idx << SHIFT));
  endfunction

  logic [PRE_W-1:0]  pre;
  logic [NUM_CH-1:0] start_q;
  logic [CSR_W-1:0]  csr_a [NUM_CH];
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  logic [CNT_W-1:0]  cmp_a [NUM_CH];

  cmt_prescaler u_pre (.clk(clk), .rst_n(rst_n), .pre_q(pre));

  always_ff @(posedge clk) begin
    if (!rst_n)                            start_q <= '0;
    else if (wr_en && addr == START_ADDR)  start_q <= wdata[NUM_CH-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (start_q[i]),
      .pre    (pre),
      .wr_csr (wr_en && addr == reg_addr(i, IDX_CSR)),
      .wr_cnt (wr_en && addr == reg_addr(i, IDX_CNT)),
      .wr_cmp (wr_en && addr == reg_addr(i, IDX_CMP)),
      .wdata  (wdata),
      .csr_q  (csr_a[i]),
      .cnt_q  (cnt_a[i]),
      .cmp_q  (cmp_a[i]),
      .irq    (irq[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (addr == START_ADDR) rdata = CNT_W'(start_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == reg_addr(i, IDX_CSR)) rdata = CNT_W'(csr_a[i]);
      if (addr == reg_addr(i, IDX_CNT)) rdata = cnt_a[i];
      if (addr == reg_addr(i, IDX_CMP)) rdata = cmp_a[i];
    end
  end
endmodule

// File: tb/test_cmt_timer.sv
module test_cmt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  cmt_timer i_cmt_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] a_csr(input int ch); return 8'(16 + 16 * ch); endfunction
  function automatic logic [7:0] a_cnt(input int ch); return 8'(18 + 16 * ch); endfunction
  function automatic logic [7:0] a_cmp(input int ch); return 8'(20 + 16 * ch); endfunction
  function automatic int period(input int cmp, input int sel);
    return (cmp + 1) * (1 << (3 + 2 * sel));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int ch, input int lim, output int t);
    t = -1;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (irq[ch]) begin t = cyc; break; end
    end
    if (t < 0) chk("R5 irq timeout", 32'd0, 32'd1);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk("watchdog", 32'd0, 32'd1);
    report();
  end

  initial begin
    logic [15:0] v, v0;
    int t1, t2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int ch = 0; ch < 2; ch++) begin
      rd(a_csr(ch), v); chk("R1 csr reset", v, 16'h0);
      rd(a_cnt(ch), v); chk("R1 cnt reset", v, 16'h0);
      rd(a_cmp(ch), v); chk("R1 cmp reset", v, 16'hFFFF);
    end
    rd(8'd0, v); chk("R1 start reset", v, 16'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 map and unused bits
    wr(8'd0, 16'hFFFF); rd(8'd0, v); chk("R2 start width", v, 16'h0003);
    wr(8'd0, 16'h0000);
    wr(a_cmp(1), 16'h1234); rd(a_cmp(1), v); chk("R2 ch1 compare address", v, 16'h1234);
    rd(a_cmp(0), v); chk("R2 ch0 compare untouched", v, 16'hFFFF);
    rd(8'd2, v); chk("R2 unmapped reads zero", v, 16'h0);

    // R8 random counter loads while stopped
    for (int i = 0; i < 4; i++) begin
      int ch = i % 2;
      logic [15:0] nv = 16'($urandom);
      wr(a_csr(ch), 16'h0040);
      rd(a_cnt(ch), v0);
      wr(a_cnt(ch), nv);
      rd(a_cnt(ch), v); chk("R8 load hidden", v, v0);
      idle(17);
      rd(a_cnt(ch), v); chk("R8 load lands", v, nv);
    end

    // R3 start bits
    for (int ch = 0; ch < 2; ch++) begin
      wr(a_csr(ch), 16'h0040); wr(a_cmp(ch), 16'hFFF0); wr(a_cnt(ch), 16'h0);
    end
    idle(20);
    wr(8'd0, 16'h0001); idle(100);
    rd(a_cnt(1), v); chk("R3 ch1 stopped", v, 16'h0);
    rd(a_cnt(0), v0); chk("R3 ch0 counts", 32'(v0 != 0), 32'd1);
    wr(8'd0, 16'h0002); rd(a_cnt(0), v0); idle(50);
    rd(a_cnt(0), v); chk("R3 ch0 holds after stop", v, v0);
    rd(a_cnt(1), v); chk("R3 ch1 counts", 32'(v != 0), 32'd1);
    wr(8'd0, 16'h0000);

    // R5 random periods at the fastest rate
    for (int i = 0; i < 6; i++) begin
      int ch = int'($urandom % 2);
      int c = 1 + int'($urandom % 12);
      wr(8'd0, 16'h0); wr(a_csr(ch), 16'h0040); wr(a_cmp(ch), 16'(c)); wr(a_cnt(ch), 16'h0);
      idle(20);
      wr(8'd0, 16'(1 << ch));
      wait_irq(ch, 400, t1);
      rd(a_cnt(ch), v); chk("R5 count zero at match", v, 16'h0);
      idle(2); chk("R7 irq held until cleared", 32'(irq[ch]), 32'd1);
      wr(a_csr(ch), 16'h0040);
      wait_irq(ch, 400, t2);
      chk("R5 period", 32'(t2 - t1), 32'(period(c, 0)));
    end

    // R6 / R7 flag handling on ch (flag currently set)
    begin
      int ch = 0;
      wr(8'd0, 16'h0); wr(a_csr(ch), 16'h0040); wr(a_cmp(ch), 16'd2); wr(a_cnt(ch), 16'h0);
      idle(20); wr(8'd0, 16'h0001);
      wait_irq(ch, 400, t1);
      wr(8'd0, 16'h0);
      wr(a_csr(ch), 16'h00C0); rd(a_csr(ch), v); chk("R6 write 1 keeps flag", v, 16'h00C0);
      wr(a_csr(ch), 16'h0080); rd(a_csr(ch), v); chk("R6 flag kept, enable off", v, 16'h0080);
      chk("R7 no irq without enable", 32'(irq[ch]), 32'd0);
      wr(a_csr(ch), 16'h00C0); chk("R7 irq with enable", 32'(irq[ch]), 32'd1);
      wr(a_csr(ch), 16'h0000); rd(a_csr(ch), v); chk("R7 zero clears flag", v, 16'h0);
      chk("R7 zero drops irq", 32'(irq[ch]), 32'd0);
      wr(a_csr(ch), 16'h00C1); rd(a_csr(ch), v); chk("R6 write cannot set flag", v, 16'h0041);
    end

    // R4 slow rate with the 0x43 setting
    wr(8'd0, 16'h0);
    wr(a_csr(1), 16'h0043); rd(a_csr(1), v); chk("R4 control readback", v, 16'h0043);
    wr(a_cmp(1), 16'd1); wr(a_cnt(1), 16'h0);
    idle(1100);
    wr(8'd0, 16'h0002);
    wait_irq(1, 3000, t1);
    wr(a_csr(1), 16'h0043);
    wait_irq(1, 3000, t2);
    chk("R4 period at 512", 32'(t2 - t1), 32'(period(1, 3)));
    wr(8'd0, 16'h0); wr(a_csr(1), 16'h0);

    // R9 compare lowered below the running count
    wr(a_csr(0), 16'h0040); wr(a_cmp(0), 16'd20); wr(a_cnt(0), 16'hFFF8);
    idle(20);
    rd(a_cnt(0), v); chk("R8 near-max load", v, 16'hFFF8);
    wr(8'd0, 16'h0001);
    wr(a_cmp(0), 16'd5);
    t1 = -1;
    for (int k = 0; k < 200; k++) begin
      rd(a_cnt(0), v);
      if (v < 16'h0010) begin t1 = cyc; break; end
    end
    chk("R9 wrapped to zero", v, 16'h0);
    rd(a_csr(0), v); chk("R9 no flag on wrap", v, 16'h0040);
    wait_irq(0, 400, t2);
    chk("R9 match after wrap", 32'(t2 - t1), 32'(6 * 8));
    wr(8'd0, 16'h0);

    report();
  end
endmodule